// File: doc/BRIEF.md
# Dual-Output Space Vector Sequencer

This block drives a three-leg, nine-switch converter whose middle switches are shared by two independent three-phase outputs. Each switching period it takes the sector of each output, four active dwell times and two zero-vector distribution factors. It then walks through a symmetric fourteen-segment pattern. Each cycle it presents the label of the vector in force, the segment index and the nine-bit gate word for that vector.

Dwell times are unsigned fixed point with `TW` fraction bits, so a value of `2**TW` means one full period. Distribution factors have `FW` fraction bits, so `2**FW` means 1.0. The period is `2**(TW+1)` clock cycles. A rising half is followed by a mirrored falling half. Each half spends exactly `t` cycles on a vector whose dwell input is `t`. All inputs are captured once per period, so a pattern never changes partway through. Computing dwell times from voltage references, inserting dead time and protecting the power stage belong to other blocks.

Top module: `dual_svm_seq`

## Requirements
- R1: Vector labels are encoded Z1=0, Z2=1, Z3=2, A=3, B=4, C=5, D=6. Within one period the segments run Z1, pair 1, Z3, pair 2, Z2, Z2, pair 2 reversed, Z3, pair 1 reversed, Z1. `seg_o` numbers them 0 to 13, and the falling half repeats the rising half's vectors in reverse order.
- R2: When output 1's sector is odd (1, 3, 5), pair 1 is A then B. When it is even (2, 4, 6), pair 1 is B then A.
- R3: Pair 2 follows the same odd/even rule for C and D, using output 2's own sector.
- R4: The total zero time is `2**TW` minus the sum of the four active times. The split is Z1 = floor(t0·α), Z2 = floor(t0·β) and Z3 = the remainder. α is clamped to 1.0, and β is clamped to 1.0−α.
- R5: The period is `2**(TW+1)` cycles. In each half, every segment lasts exactly its dwell value in cycles.
- R6: A segment with zero duration never appears on the outputs, not even for one cycle.
- R7: Sectors, dwell times and factors are captured at the first clock edge after reset and then at each period boundary. Input changes inside a period take effect only at the next period.
- R8: If the active times sum to more than `2**TW`, or either sector is outside 1 to 6, then `err_o` is high and the label is Z1 for that whole period. The next valid capture restores normal operation.
- R9: `gate_o[3i+2]`, `gate_o[3i+1]` and `gate_o[3i]` are the top, middle and bottom switches of leg i (leg a is i=0). Each leg has exactly two switches on. The top switch equals the upper leg level u. The bottom switch is the inverse of the lower leg level l. The middle switch is on unless u=1 and l=0.
- R10: Leg levels (u,l) per label: Z1=(000,000), Z3=(111,000), Z2=(111,111), A=(E(s1),000), B=(E(s1+1),000), C=(111,E(s2)), D=(111,E(s2+1)). Here E(1..6) = 001, 011, 010, 110, 100, 101 in bit order (c,b,a), and sector 6+1 wraps to 1.
- R11: While reset is held, the outputs show label Z1, segment 13, `err_o` low and gate word 011011011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sec1_i | input | 3 | Sector of output 1 (1..6) |
| sec2_i | input | 3 | Sector of output 2 (1..6) |
| ta_i | input | TW+1 | Dwell of vector A (output 1, sector start edge) |
| tb_i | input | TW+1 | Dwell of vector B (output 1, sector end edge) |
| tc_i | input | TW+1 | Dwell of vector C (output 2, sector start edge) |
| td_i | input | TW+1 | Dwell of vector D (output 2, sector end edge) |
| alpha_i | input | FW+1 | Share of zero time given to Z1 |
| beta_i | input | FW+1 | Share of zero time given to Z2 |
| vec_o | output | 3 | Current vector label |
| seg_o | output | 4 | Current segment index 0..13 |
| gate_o | output | 9 | Gate word, three switches per leg |
| err_o | output | 1 | Captured inputs over-range or invalid sector |

## Verification
The bench builds the block with TW=4 and FW=3. That gives a 32-cycle period and factors in eighths, so every tick of every period can be compared against an expected pattern at low cost. At this width, full utilisation (zero time of nil), an overrun of one LSB, and the clamp of β at 1.0−α all fall on small integers that are checked exactly. Every odd/even sector pairing is covered, including the 6-to-1 wrap.

// File: rtl/svs_pkg.sv
package svs_pkg;

  typedef enum logic [2:0] {
    VL_Z1 = 3'd0,
    VL_Z2 = 3'd1,
    VL_Z3 = 3'd2,
    VL_A  = 3'd3,
    VL_B  = 3'd4,
    VL_C  = 3'd5,
    VL_D  = 3'd6
  } vec_lbl_e;

  // leg levels of the sector-edge vector, bit i = leg i
  function automatic logic [2:0] sv_legs(input logic [2:0] s);
    case (s)
      3'd1:    sv_legs = 3'b001;
      3'd2:    sv_legs = 3'b011;
      3'd3:    sv_legs = 3'b010;
      3'd4:    sv_legs = 3'b110;
      3'd5:    sv_legs = 3'b100;
      3'd6:    sv_legs = 3'b101;
      default: sv_legs = 3'b000;
    endcase
  endfunction

  function automatic logic [2:0] sec_next(input logic [2:0] s);
    sec_next = (s == 3'd6) ? 3'd1 : 3'(s + 3'd1);
  endfunction

  function automatic logic sec_ok(input logic [2:0] s);
    sec_ok = (s >= 3'd1) && (s <= 3'd6);
  endfunction

endpackage

// File: rtl/svs_timer.sv
module svs_timer #(
  parameter int unsigned TW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [TW-1:0] cnt_o,
  output logic          dn_o,
  output logic          ld_o
);
  localparam logic [TW-1:0] CMAX = '1;

  logic [TW-1:0] cnt_q;
  logic          dn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dn_q  <= 1'b1;
    end else if (dn_q) begin
      if (cnt_q == '0) dn_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end else begin
      if (cnt_q == CMAX) dn_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign dn_o  = dn_q;
  assign ld_o  = dn_q && (cnt_q == '0);

  a_r7_load_starts_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_o |=> (cnt_o == '0 && !dn_o));

  a_r5_turn_at_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dn_o && cnt_o == CMAX) |=> (dn_o && cnt_o == CMAX));

endmodule

// File: rtl/svs_shadow.sv
module svs_shadow
  import svs_pkg::*;
#(
  parameter int unsigned TW = 6,
  parameter int unsigned FW = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [2:0]        sec1_i,
  input  logic [2:0]        sec2_i,
  input  logic [TW:0]       ta_i,
  input  logic [TW:0]       tb_i,
  input  logic [TW:0]       tc_i,
  input  logic [TW:0]       td_i,
  input  logic [FW:0]       alpha_i,
  input  logic [FW:0]       beta_i,
  output logic [2:0]        sec1_o,
  output logic [2:0]        sec2_o,
  output logic              err_o,
  output logic [6:0][TW:0]  dur_o
);
  localparam int unsigned SW = TW + 3;
  localparam int unsigned PW = TW + FW + 2;
  localparam logic [TW:0] FULL_T = (TW+1)'(1 << TW);
  localparam logic [FW:0] ONE_F  = (FW+1)'(1 << FW);

  logic [2:0]  sec1_q, sec2_q;
  logic [TW:0] ta_q, tb_q, tc_q, td_q;
  logic [FW:0] al_q, be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec1_q <= 3'd1;
      sec2_q <= 3'd1;
      ta_q   <= '0;
      tb_q   <= '0;
      tc_q   <= '0;
      td_q   <= '0;
      al_q   <= ONE_F;
      be_q   <= '0;
    end else if (ld_i) begin
      sec1_q <= sec1_i;
      sec2_q <= sec2_i;
      ta_q   <= ta_i;
      tb_q   <= tb_i;
      tc_q   <= tc_i;
      td_q   <= td_i;
      al_q   <= alpha_i;
      be_q   <= beta_i;
    end
  end

  logic [SW-1:0] act_sum;
  logic          bad;
  logic [TW:0]   t0, t01, t02, t03;
  logic [FW:0]   a_e, b_e;
  logic [FW+1:0] ab_sum;
  logic [PW-1:0] p01, p02;

  always_comb begin
    act_sum = SW'(ta_q) + SW'(tb_q) + SW'(tc_q) + SW'(td_q);
    bad     = (act_sum > SW'(FULL_T)) || !sec_ok(sec1_q) || !sec_ok(sec2_q);
    t0      = bad ? '0 : FULL_T - act_sum[TW:0];
    a_e     = (al_q > ONE_F) ? ONE_F : al_q;
    ab_sum  = (FW+2)'(a_e) + (FW+2)'(be_q);
    b_e     = (ab_sum > (FW+2)'(ONE_F)) ? ONE_F - a_e : be_q;
    p01     = PW'(t0) * PW'(a_e);
    p02     = PW'(t0) * PW'(b_e);
    t01     = (TW+1)'(p01 >> FW);
    t02     = (TW+1)'(p02 >> FW);
    t03     = t0 - t01 - t02;
  end

  always_comb begin
    if (bad) begin
      dur_o    = '0;
      dur_o[0] = FULL_T;
    end else begin
      dur_o[0] = t01;
      dur_o[1] = sec1_q[0] ? ta_q : tb_q;
      dur_o[2] = sec1_q[0] ? tb_q : ta_q;
      dur_o[3] = t03;
      dur_o[4] = sec2_q[0] ? tc_q : td_q;
      dur_o[5] = sec2_q[0] ? td_q : tc_q;
      dur_o[6] = t02;
    end
  end

  assign sec1_o = sec1_q;
  assign sec2_o = sec2_q;
  assign err_o  = bad;

  a_r4_zero_split_fits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bad |-> ((TW+2)'(t01) + (TW+2)'(t02) <= (TW+2)'(t0)));

endmodule

// File: rtl/svs_seg_sel.sv
module svs_seg_sel #(
  parameter int unsigned TW = 6
) (
  input  logic [TW-1:0]     cnt_i,
  input  logic              dn_i,
  input  logic [6:0][TW:0]  dur_i,
  output logic [2:0]        slot_o,
  output logic [3:0]        seg_o
);
  logic [TW+1:0] cum;
  logic          found;

  always_comb begin
    cum    = '0;
    found  = 1'b0;
    slot_o = 3'd6;
    for (int k = 0; k < 7; k++) begin
      cum = cum + (TW+2)'(dur_i[k]);
      if (!found && ((TW+2)'(cnt_i) < cum)) begin
        slot_o = 3'(k);
        found  = 1'b1;
      end
    end
    seg_o = dn_i ? 4'(4'd13 - {1'b0, slot_o}) : {1'b0, slot_o};
  end

endmodule

// File: rtl/svs_gate_map.sv
module svs_gate_map
  import svs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  vec_lbl_e   lbl_i,
  input  logic [2:0] sec1_i,
  input  logic [2:0] sec2_i,
  output logic [8:0] gate_o
);
  logic [2:0] up_lv, lo_lv;

  always_comb begin
    unique case (lbl_i)
      VL_Z2:   begin up_lv = 3'b111;                   lo_lv = 3'b111; end
      VL_Z3:   begin up_lv = 3'b111;                   lo_lv = 3'b000; end
      VL_A:    begin up_lv = sv_legs(sec1_i);          lo_lv = 3'b000; end
      VL_B:    begin up_lv = sv_legs(sec_next(sec1_i)); lo_lv = 3'b000; end
      VL_C:    begin up_lv = 3'b111; lo_lv = sv_legs(sec2_i);          end
      VL_D:    begin up_lv = 3'b111; lo_lv = sv_legs(sec_next(sec2_i)); end
      default: begin up_lv = 3'b000;                   lo_lv = 3'b000; end
    endcase
  end

  for (genvar i = 0; i < 3; i++) begin : g_leg
    assign gate_o[3*i+2] = up_lv[i];
    assign gate_o[3*i+1] = ~up_lv[i] | lo_lv[i];
    assign gate_o[3*i]   = ~lo_lv[i];

    a_r9_two_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(gate_o[3*i +: 3]) == 2);
  end

endmodule

// File: rtl/dual_svm_seq.sv
module dual_svm_seq
  import svs_pkg::*;
#(
  parameter int unsigned TW = 6,
  parameter int unsigned FW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    sec1_i,
  input  logic [2:0]    sec2_i,
  input  logic [TW:0]   ta_i,
  input  logic [TW:0]   tb_i,
  input  logic [TW:0]   tc_i,
  input  logic [TW:0]   td_i,
  input  logic [FW:0]   alpha_i,
  input  logic [FW:0]   beta_i,
  output logic [2:0]    vec_o,
  output logic [3:0]    seg_o,
  output logic [8:0]    gate_o,
  output logic          err_o
);
  logic [TW-1:0]     cnt;
  logic              dn, ld;
  logic [2:0]        s1, s2, slot;
  logic [6:0][TW:0]  dur;
  vec_lbl_e          lbl;

  svs_timer #(.TW(TW)) u_timer (
    .clk_i (clk_i), .rst_ni(rst_ni), .cnt_o(cnt), .dn_o(dn), .ld_o(ld)
  );

  svs_shadow #(.TW(TW), .FW(FW)) u_shadow (
    .clk_i  (clk_i),  .rst_ni (rst_ni), .ld_i   (ld),
    .sec1_i (sec1_i), .sec2_i (sec2_i),
    .ta_i   (ta_i),   .tb_i   (tb_i),   .tc_i   (tc_i), .td_i(td_i),
    .alpha_i(alpha_i), .beta_i(beta_i),
    .sec1_o (s1),     .sec2_o (s2),     .err_o  (err_o), .dur_o(dur)
  );

  svs_seg_sel #(.TW(TW)) u_sel (
    .cnt_i(cnt), .dn_i(dn), .dur_i(dur), .slot_o(slot), .seg_o(seg_o)
  );

  always_comb begin
    unique case (slot)
      3'd1:    lbl = s1[0] ? VL_A : VL_B;
      3'd2:    lbl = s1[0] ? VL_B : VL_A;
      3'd3:    lbl = VL_Z3;
      3'd4:    lbl = s2[0] ? VL_C : VL_D;
      3'd5:    lbl = s2[0] ? VL_D : VL_C;
      3'd6:    lbl = VL_Z2;
      default: lbl = VL_Z1;
    endcase
  end

  svs_gate_map u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .lbl_i(lbl),
    .sec1_i(s1), .sec2_i(s2), .gate_o(gate_o)
  );

  assign vec_o = lbl;

  logic [TW+3:0] dur_sum;
  always_comb begin
    dur_sum = '0;
    for (int k = 0; k < 7; k++) dur_sum = dur_sum + (TW+4)'(dur[k]);
  end

  a_r6_no_empty_seg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dur[slot] != '0);

  a_r5_half_filled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dur_sum == (TW+4)'(1 << TW));

  a_r8_err_holds_z1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (vec_o == VL_Z1));

  a_r1_seg_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_o < $past(seg_o)) |-> (cnt == '0 && !dn));

endmodule

// File: tb/tb_dual_svm_seq.sv
module tb_dual_svm_seq;
  localparam int TW = 4;
  localparam int FW = 3;
  localparam int HALF = 1 << TW;
  localparam int PER  = 2 * HALF;
  localparam int ONE  = 1 << FW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    sec1, sec2;
  logic [TW:0]   ta, tb, tc, td;
  logic [FW:0]   al, be;
  logic [2:0]    vec;
  logic [3:0]    seg;
  logic [8:0]    gate;
  logic          err;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dual_svm_seq #(.TW(TW), .FW(FW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sec1_i(sec1), .sec2_i(sec2),
    .ta_i(ta), .tb_i(tb), .tc_i(tc), .td_i(td),
    .alpha_i(al), .beta_i(be),
    .vec_o(vec), .seg_o(seg), .gate_o(gate), .err_o(err)
  );

  task automatic check(string tag, bit ok, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int legs(int s);
    case (s)
      1: return 1; 2: return 3; 3: return 2;
      4: return 6; 5: return 4; 6: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic int nxt(int s);
    return (s == 6) ? 1 : s + 1;
  endfunction

  // R9 / R10 expected gate word
  function automatic int exp_gate(int lbl, int s1, int s2);
    int u, l, g;
    case (lbl)
      1: begin u = 7; l = 7; end
      2: begin u = 7; l = 0; end
      3: begin u = legs(s1); l = 0; end
      4: begin u = legs(nxt(s1)); l = 0; end
      5: begin u = 7; l = legs(s2); end
      6: begin u = 7; l = legs(nxt(s2)); end
      default: begin u = 0; l = 0; end
    endcase
    g = 0;
    for (int i = 0; i < 3; i++) begin
      int ub, lb;
      ub = (u >> i) & 1;
      lb = (l >> i) & 1;
      g |= ub << (3*i+2);
      g |= ((ub == 0 || lb == 1) ? 1 : 0) << (3*i+1);
      g |= (1 - lb) << (3*i);
    end
    return g;
  endfunction

  task automatic drive(int s1, int s2, int a, int b, int c, int d, int fa, int fb);
    sec1 = 3'(s1); sec2 = 3'(s2);
    ta = (TW+1)'(a); tb = (TW+1)'(b); tc = (TW+1)'(c); td = (TW+1)'(d);
    al = (FW+1)'(fa); be = (FW+1)'(fb);
  endtask

  // Runs one period with these inputs; optional mid-period change (R7).
  task automatic run_period(string tag, int s1, int s2, int a, int b, int c, int d,
                            int fa, int fb, bit chg);
    int dur[7];
    int lab[7];
    int sum, t0, ae, bn, bad;
    int f_lbl, f_gate, f_err;
    int a_act, a_exp, g_act, g_exp, e_act;
    drive(s1, s2, a, b, c, d, fa, fb);
    sum = a + b + c + d;
    bad = (sum > HALF || s1 < 1 || s1 > 6 || s2 < 1 || s2 > 6) ? 1 : 0;
    t0 = bad ? 0 : HALF - sum;
    ae = (fa > ONE) ? ONE : fa;
    bn = (ae + fb > ONE) ? ONE - ae : fb;
    dur[0] = (t0 * ae) / ONE;
    dur[6] = (t0 * bn) / ONE;
    dur[3] = t0 - dur[0] - dur[6];
    dur[1] = (s1 % 2) ? a : b;  lab[1] = (s1 % 2) ? 3 : 4;
    dur[2] = (s1 % 2) ? b : a;  lab[2] = (s1 % 2) ? 4 : 3;
    dur[4] = (s2 % 2) ? c : d;  lab[4] = (s2 % 2) ? 5 : 6;
    dur[5] = (s2 % 2) ? d : c;  lab[5] = (s2 % 2) ? 6 : 5;
    lab[0] = 0; lab[3] = 2; lab[6] = 1;
    if (bad) begin
      for (int j = 0; j < 7; j++) dur[j] = 0;
      dur[0] = HALF;
    end
    f_lbl = 0; f_gate = 0; f_err = 0;
    a_act = 0; a_exp = 0; g_act = 0; g_exp = 0; e_act = 0;
    for (int n = 0; n < PER; n++) begin
      int h, cum, k, el, es, eg;
      bit fnd;
      @(posedge clk);
      @(negedge clk);
      if (chg && n == 5) drive(nxt(s1), nxt(s2), 1, 1, 1, 1, 0, 0);
      h = (n < HALF) ? n : PER - 1 - n;
      cum = 0; k = 6; fnd = 0;
      for (int j = 0; j < 7; j++) begin
        cum += dur[j];
        if (!fnd && h < cum) begin k = j; fnd = 1; end
      end
      el = lab[k];
      es = (n < HALF) ? k : 13 - k;
      eg = exp_gate(el, s1, s2);
      if (f_lbl == 0 && (int'(vec) != el || int'(seg) != es)) begin
        f_lbl = 1; a_act = int'(vec) * 100 + int'(seg); a_exp = el * 100 + es;
      end
      if (f_gate == 0 && int'(gate) != eg) begin
        f_gate = 1; g_act = int'(gate); g_exp = eg;
      end
      if (f_err == 0 && int'(err) != bad) begin
        f_err = 1; e_act = int'(err);
      end
    end
    check({tag, " vec*100+seg"}, f_lbl == 0, a_act, a_exp);
    check({tag, " R9 gate"}, f_gate == 0, g_act, g_exp);
    check({tag, " R8 err"}, f_err == 0, e_act, bad);
  endtask

  task automatic t_reset;
    check("R11 reset vec", vec == 3'd0, int'(vec), 0);
    check("R11 reset seg", seg == 4'd13, int'(seg), 13);
    check("R11 reset err", err == 1'b0, int'(err), 0);
    check("R11 reset gate", gate == 9'b011011011, int'(gate), 9'b011011011);
  endtask

  task automatic t_odd_sectors;    // R1 R2 R3 R4 R5
    run_period("R1/R2/R3/R4/R5 odd-odd", 1, 3, 3, 2, 4, 1, 4, 2, 0);
    run_period("R2/R3 odd-odd s5", 5, 5, 2, 3, 1, 2, 2, 3, 0);
  endtask

  task automatic t_even_sectors;   // R2 R3 R10 wrap 6->1
    run_period("R2/R3/R10 even-even", 2, 6, 3, 1, 2, 2, 4, 4, 0);
    run_period("R2/R3/R10 even-odd", 6, 1, 1, 4, 2, 3, 3, 2, 0);
    run_period("R2/R3 odd-even", 3, 4, 2, 2, 3, 1, 5, 1, 0);
  endtask

  task automatic t_zero_skip;      // R6
    run_period("R6 no Z1/Z2, tb=0", 1, 2, 4, 0, 3, 2, 0, 0, 0);
    run_period("R6 full use, no zeros", 4, 3, 5, 3, 6, 2, 4, 4, 0);
  endtask

  task automatic t_beta_clamp;     // R4
    run_period("R4 beta clamp", 2, 2, 2, 2, 2, 2, 6, 6, 0);
    run_period("R4 alpha over one", 1, 1, 1, 1, 1, 1, 12, 3, 0);
  endtask

  task automatic t_latch;          // R7
    run_period("R7 mid-period change held", 1, 5, 3, 2, 2, 1, 4, 2, 1);
    run_period("R7 change applied next", 2, 6, 1, 1, 1, 1, 0, 0, 0);
  endtask

  task automatic t_error;          // R8
    run_period("R8 overrun by one", 1, 1, 5, 4, 4, 4, 4, 2, 0);
    run_period("R8 bad sector", 7, 2, 1, 1, 1, 1, 4, 2, 0);
    run_period("R8 bad sector zero", 3, 0, 1, 1, 1, 1, 4, 2, 0);
    run_period("R8 recovery", 3, 2, 2, 3, 2, 1, 2, 2, 0);
  endtask

  initial begin
    drive(1, 1, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    t_odd_sectors();
    t_even_sectors();
    t_zero_skip();
    t_beta_clamp();
    t_latch();
    t_error();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule